// File: doc/BRIEF.md
# I2C Host Register Front End

This block is the software-facing half of an I2C master controller. It decodes a 32-bit register bus and keeps the settings a separate bit-level bus sequencer needs: the command flags, the 10-bit target address, two clock divisors and the number of bytes to receive. It also holds two 16-byte FIFOs that share one data port. Bus writes to the data port go into the transmit FIFO, and the sequencer drains it. The sequencer fills the receive FIFO, and bus reads from the data port drain it.

A transfer begins when software sets the start flag. The flag stays set until the sequencer accepts the request. The sequencer reports three events back to the block: transfer complete, address not acknowledged and data not acknowledged. These latch into a status register. The status register drives a level interrupt through an enable bit. Software clears every latched flag at once by writing a single acknowledge bit.

Register reads are registered: the value appears on `bus_rdata` in the cycle after the access. All state resets synchronously on `rst`.

Top module: `i2ch_front`

## Requirements
- R1: Word registers sit at these byte offsets: command 0x04, address high 0x0C, address low 0x10, fast divisor 0x14, high-speed divisor 0x18, transmit config 0x1C, receive config 0x20, data 0x24, status 0x28. The two divisors hold the full 32 bits and drive `seq_div_fast` and `seq_div_hs`. Address low keeps bits 6:0 and address high keeps bits 2:0, and `seq_dev_addr` is {high, low}. Reads from other offsets return 0. After reset every register reads 0.
- R2: The command register has these bits: 0 master enable, 1 ten-bit mode, 3 interrupt enable, 4 read direction, 5 combined write-then-read, 6 start. Bit 2 reads as 0. Bits 0, 1, 4 and 5 drive `seq_master_en`, `seq_ten_bit`, `seq_read` and `seq_combined`.
- R3: Writing 1 to command bit 6 while idle raises `seq_start` in the next cycle, and bit 6 then reads back as 1. The flag stays set until a cycle in which `seq_accept` is high. It is low in the cycle after that.
- R4: A start written while `seq_busy` is high, or while a start is already pending, has no effect.
- R5: Each write to the data port pushes bits 7:0 into the transmit FIFO. `seq_tx_data` shows the oldest byte and `seq_tx_empty` flags an empty FIFO. A `seq_tx_pop` pulse removes one byte. Bytes leave in the order they were written.
- R6: A push into a transmit FIFO that already holds 16 bytes is dropped, and the 16 stored bytes are unchanged.
- R7: A `seq_rx_push` pulse stores `seq_rx_data` in the receive FIFO, and `seq_rx_full` flags 16 stored bytes. A push into a full receive FIFO is dropped. Data-port reads return the stored bytes in order. A read from an empty receive FIFO returns 0x00.
- R8: Writing bit 7 of the transmit config register empties the transmit FIFO. Writing bit 7 of the receive config register empties the receive FIFO. Bit 7 always reads back as 0, and bits 3:0 are kept. The receive config bits 3:0 drive `seq_rx_count` (bytes to receive minus one).
- R9: Pulses on `ev_done`, `ev_addr_nak` and `ev_data_nak` set status bits 0, 1 and 2, and those bits stay set. Status bits 6:3 read as 0.
- R10: A status write with bit 7 set clears all status bits. A status write with bit 7 clear changes nothing. An event that arrives in the same cycle as the clear stays latched.
- R11: `irq` equals (any status bit set) AND (command bit 3). It changes on the same clock edge as the status or enable change that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after a read |
| seq_start | output | 1 | Transfer request to the sequencer |
| seq_accept | input | 1 | Sequencer takes the request |
| seq_busy | input | 1 | Sequencer is running a transfer |
| seq_master_en | output | 1 | Master enable |
| seq_ten_bit | output | 1 | Ten-bit addressing |
| seq_read | output | 1 | Read direction |
| seq_combined | output | 1 | Write-then-read transfer |
| seq_dev_addr | output | ADR_W | Target address |
| seq_rx_count | output | CNT_W | Bytes to receive minus one |
| seq_div_fast | output | DATA_W | Fast-mode divisor |
| seq_div_hs | output | DATA_W | High-speed divisor |
| seq_tx_data | output | 8 | Oldest transmit byte |
| seq_tx_empty | output | 1 | Transmit FIFO empty |
| seq_tx_pop | input | 1 | Remove one transmit byte |
| seq_rx_data | input | 8 | Received byte |
| seq_rx_push | input | 1 | Store one received byte |
| seq_rx_full | output | 1 | Receive FIFO full |
| ev_done | input | 1 | Transfer complete event |
| ev_addr_nak | input | 1 | Address not acknowledged event |
| ev_data_nak | input | 1 | Data not acknowledged event |
| irq | output | 1 | Level interrupt |

## Verification
The hardest case to reach is an event pulse that lands in the same clock cycle as the status acknowledge write, where the event must survive the clear. The stimulus gets there by raising `ev_data_nak` in the same falling-edge slot that presents the clearing write. FIFO overflow is reached by pushing 17 or more bytes with no drain in between. Random-length rounds run the FIFOs through fill levels both below and above full, and each round checks the drained byte order against a model in the bench.

// File: rtl/i2ch_pkg.sv
package i2ch_pkg;
  // word index = byte offset >> 2
  localparam logic [3:0] IDX_CMD    = 4'd1;
  localparam logic [3:0] IDX_ADR_HI = 4'd3;
  localparam logic [3:0] IDX_ADR_LO = 4'd4;
  localparam logic [3:0] IDX_DIV_FS = 4'd5;
  localparam logic [3:0] IDX_DIV_HS = 4'd6;
  localparam logic [3:0] IDX_TX_CFG = 4'd7;
  localparam logic [3:0] IDX_RX_CFG = 4'd8;
  localparam logic [3:0] IDX_DATA   = 4'd9;
  localparam logic [3:0] IDX_STAT   = 4'd10;

  localparam int CB_MASTER = 0;
  localparam int CB_TEN    = 1;
  localparam int CB_IE     = 3;
  localparam int CB_READ   = 4;
  localparam int CB_COMB   = 5;
  localparam int CB_START  = 6;
  localparam int FLUSH_BIT = 7;
  localparam int ACK_BIT   = 7;

  typedef struct packed {
    logic comb;
    logic rd;
    logic ie;
    logic ten;
    logic master;
  } cmd_cfg_t;
endpackage

// File: rtl/i2ch_byte_fifo.sv
module i2ch_byte_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic              full,
  output logic              empty,
  output logic [PTR_W:0]    level
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W:0] wr_ptr, rd_ptr;
  logic do_push, do_pop;

  assign empty   = (wr_ptr == rd_ptr);
  assign full    = (wr_ptr[PTR_W] != rd_ptr[PTR_W]) &&
                   (wr_ptr[PTR_W-1:0] == rd_ptr[PTR_W-1:0]);
  assign level   = wr_ptr - rd_ptr;
  assign do_push = push & ~full & ~flush;
  assign do_pop  = pop & ~empty & ~flush;
  assign head    = empty ? '0 : mem[rd_ptr[PTR_W-1:0]];

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr[PTR_W-1:0]] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
    end
  end
endmodule

// File: rtl/i2ch_cmd_ctl.sv
module i2ch_cmd_ctl
  import i2ch_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     wr_en,
  input  cmd_cfg_t wr_cfg,
  input  logic     start_req,
  input  logic     seq_accept,
  input  logic     seq_busy,
  output cmd_cfg_t cfg,
  output cmd_cfg_t cfg_next,
  output logic     start
);
  assign cfg_next = wr_en ? wr_cfg : cfg;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg   <= '0;
      start <= 1'b0;
    end else begin
      cfg <= cfg_next;
      if (start && seq_accept)
        start <= 1'b0;
      else if (wr_en && start_req && !seq_busy && !start)
        start <= 1'b1;
    end
  end
endmodule

// File: rtl/i2ch_status.sv
module i2ch_status #(
  parameter int N_SRC = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] events,
  input  logic             ack_clear,
  input  logic             irq_en_next,
  output logic [N_SRC-1:0] status,
  output logic             irq
);
  logic [N_SRC-1:0] st_d;

  // a new event beats a clear arriving in the same cycle
  assign st_d = (ack_clear ? '0 : status) | events;

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      irq    <= 1'b0;
    end else begin
      status <= st_d;
      irq    <= (|st_d) & irq_en_next;
    end
  end
endmodule

// File: rtl/i2ch_front.sv
module i2ch_front
  import i2ch_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 6,
  parameter int FIFO_DEPTH = 16,
  parameter int ADR_W      = 10,
  localparam int CNT_W     = $clog2(FIFO_DEPTH),
  localparam int LO_W      = 7,
  localparam int HI_W      = ADR_W - LO_W,
  localparam int IDX_W     = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              seq_start,
  input  logic              seq_accept,
  input  logic              seq_busy,
  output logic              seq_master_en,
  output logic              seq_ten_bit,
  output logic              seq_read,
  output logic              seq_combined,
  output logic [ADR_W-1:0]  seq_dev_addr,
  output logic [CNT_W-1:0]  seq_rx_count,
  output logic [DATA_W-1:0] seq_div_fast,
  output logic [DATA_W-1:0] seq_div_hs,
  output logic [7:0]        seq_tx_data,
  output logic              seq_tx_empty,
  input  logic              seq_tx_pop,
  input  logic [7:0]        seq_rx_data,
  input  logic              seq_rx_push,
  output logic              seq_rx_full,
  input  logic              ev_done,
  input  logic              ev_addr_nak,
  input  logic              ev_data_nak,
  output logic              irq
);
  logic [IDX_W-1:0] idx;
  logic aligned, wr_acc, rd_acc;
  logic [HI_W-1:0]   adr_hi_q;
  logic [LO_W-1:0]   adr_lo_q;
  logic [CNT_W-1:0]  tx_cfg_q, rx_cfg_q;
  logic [DATA_W-1:0] div_fs_q, div_hs_q;
  logic [DATA_W-1:0] rd_mux;
  logic [2:0]        stat_q;
  logic              ack_clear, irq_en_q;
  cmd_cfg_t          cfg_q, cfg_nx, cfg_wr;
  logic              tx_push, tx_flush, tx_full, rx_pop, rx_flush, rx_empty;
  logic [CNT_W:0]    tx_level, rx_level;
  logic [7:0]        rx_head;

  assign idx     = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign wr_acc  = bus_sel & bus_wr & aligned;
  assign rd_acc  = bus_sel & ~bus_wr;

  function automatic logic hit(input logic [IDX_W-1:0] i, input logic [3:0] r);
    return i == IDX_W'(r);
  endfunction

  assign cfg_wr = '{comb:   bus_wdata[CB_COMB],
                    rd:     bus_wdata[CB_READ],
                    ie:     bus_wdata[CB_IE],
                    ten:    bus_wdata[CB_TEN],
                    master: bus_wdata[CB_MASTER]};

  i2ch_cmd_ctl u_cmd (
    .clk(clk), .rst(rst),
    .wr_en(wr_acc && hit(idx, IDX_CMD)),
    .wr_cfg(cfg_wr), .start_req(bus_wdata[CB_START]),
    .seq_accept(seq_accept), .seq_busy(seq_busy),
    .cfg(cfg_q), .cfg_next(cfg_nx), .start(seq_start)
  );

  assign ack_clear = wr_acc && hit(idx, IDX_STAT) && bus_wdata[ACK_BIT];
  assign irq_en_q  = cfg_q.ie;

  i2ch_status #(.N_SRC(3)) u_stat (
    .clk(clk), .rst(rst),
    .events({ev_data_nak, ev_addr_nak, ev_done}),
    .ack_clear(ack_clear), .irq_en_next(cfg_nx.ie),
    .status(stat_q), .irq(irq)
  );

  assign tx_push  = wr_acc && hit(idx, IDX_DATA);
  assign tx_flush = wr_acc && hit(idx, IDX_TX_CFG) && bus_wdata[FLUSH_BIT];
  assign rx_pop   = rd_acc && aligned && hit(idx, IDX_DATA);
  assign rx_flush = wr_acc && hit(idx, IDX_RX_CFG) && bus_wdata[FLUSH_BIT];

  i2ch_byte_fifo #(.DATA_W(8), .DEPTH(FIFO_DEPTH)) u_tx (
    .clk(clk), .rst(rst), .flush(tx_flush),
    .push(tx_push), .push_data(bus_wdata[7:0]),
    .pop(seq_tx_pop), .head(seq_tx_data),
    .full(tx_full), .empty(seq_tx_empty), .level(tx_level)
  );

  i2ch_byte_fifo #(.DATA_W(8), .DEPTH(FIFO_DEPTH)) u_rx (
    .clk(clk), .rst(rst), .flush(rx_flush),
    .push(seq_rx_push), .push_data(seq_rx_data),
    .pop(rx_pop), .head(rx_head),
    .full(seq_rx_full), .empty(rx_empty), .level(rx_level)
  );

  // plain configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      adr_hi_q <= '0;
      adr_lo_q <= '0;
      div_fs_q <= '0;
      div_hs_q <= '0;
      tx_cfg_q <= '0;
      rx_cfg_q <= '0;
    end else if (wr_acc) begin
      if (hit(idx, IDX_ADR_HI)) adr_hi_q <= bus_wdata[HI_W-1:0];
      if (hit(idx, IDX_ADR_LO)) adr_lo_q <= bus_wdata[LO_W-1:0];
      if (hit(idx, IDX_DIV_FS)) div_fs_q <= bus_wdata;
      if (hit(idx, IDX_DIV_HS)) div_hs_q <= bus_wdata;
      if (hit(idx, IDX_TX_CFG)) tx_cfg_q <= bus_wdata[CNT_W-1:0];
      if (hit(idx, IDX_RX_CFG)) rx_cfg_q <= bus_wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (aligned) begin
      if (hit(idx, IDX_CMD)) begin
        rd_mux[CB_MASTER] = cfg_q.master;
        rd_mux[CB_TEN]    = cfg_q.ten;
        rd_mux[CB_IE]     = cfg_q.ie;
        rd_mux[CB_READ]   = cfg_q.rd;
        rd_mux[CB_COMB]   = cfg_q.comb;
        rd_mux[CB_START]  = seq_start;
      end
      if (hit(idx, IDX_ADR_HI)) rd_mux[HI_W-1:0]  = adr_hi_q;
      if (hit(idx, IDX_ADR_LO)) rd_mux[LO_W-1:0]  = adr_lo_q;
      if (hit(idx, IDX_DIV_FS)) rd_mux            = div_fs_q;
      if (hit(idx, IDX_DIV_HS)) rd_mux            = div_hs_q;
      if (hit(idx, IDX_TX_CFG)) rd_mux[CNT_W-1:0] = tx_cfg_q;
      if (hit(idx, IDX_RX_CFG)) rd_mux[CNT_W-1:0] = rx_cfg_q;
      if (hit(idx, IDX_DATA))   rd_mux[7:0]       = rx_head;
      if (hit(idx, IDX_STAT))   rd_mux[2:0]       = stat_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (rd_acc) bus_rdata <= rd_mux;
  end

  assign seq_master_en = cfg_q.master;
  assign seq_ten_bit   = cfg_q.ten;
  assign seq_read      = cfg_q.rd;
  assign seq_combined  = cfg_q.comb;
  assign seq_dev_addr  = {adr_hi_q, adr_lo_q};
  assign seq_rx_count  = rx_cfg_q;
  assign seq_div_fast  = div_fs_q;
  assign seq_div_hs    = div_hs_q;
endmodule

// File: rtl/i2ch_front_chk.sv
module i2ch_front_chk #(
  parameter int LVL_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             seq_start,
  input logic             seq_accept,
  input logic             seq_busy,
  input logic             tx_push,
  input logic             tx_flush,
  input logic             tx_full,
  input logic             seq_tx_pop,
  input logic [LVL_W-1:0] tx_level,
  input logic             ack_clear,
  input logic [2:0]       stat,
  input logic             ev_done,
  input logic             ev_addr_nak,
  input logic             ev_data_nak,
  input logic             ie,
  input logic             irq
);
  // R3
  start_release_chk: assert property (@(posedge clk) disable iff (rst)
    seq_start && seq_accept |=> !seq_start);
  // R4
  start_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    seq_busy && !seq_start |=> !seq_start);
  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    tx_full && tx_push && !seq_tx_pop && !tx_flush |=> $stable(tx_level));
  // R8
  flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
    tx_flush |=> tx_level == '0);
  // R9
  event_latch_chk: assert property (@(posedge clk) disable iff (rst)
    ev_done |=> stat[0]);
  // R10
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ack_clear && !(ev_done || ev_addr_nak || ev_data_nak) |=> stat == 3'b000);
  // R11
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> ie);
endmodule

bind i2ch_front i2ch_front_chk #(.LVL_W(CNT_W + 1)) u_chk (
  .clk(clk), .rst(rst),
  .seq_start(seq_start), .seq_accept(seq_accept), .seq_busy(seq_busy),
  .tx_push(tx_push), .tx_flush(tx_flush), .tx_full(tx_full),
  .seq_tx_pop(seq_tx_pop), .tx_level(tx_level),
  .ack_clear(ack_clear), .stat(stat_q),
  .ev_done(ev_done), .ev_addr_nak(ev_addr_nak), .ev_data_nak(ev_data_nak),
  .ie(irq_en_q), .irq(irq)
);

// File: tb/i2ch_front_bench.sv
`timescale 1ns/1ps
module i2ch_front_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic seq_start, seq_accept = 1'b0, seq_busy = 1'b0;
  logic seq_master_en, seq_ten_bit, seq_read, seq_combined;
  logic [9:0] seq_dev_addr;
  logic [3:0] seq_rx_count;
  logic [31:0] seq_div_fast, seq_div_hs;
  logic [7:0] seq_tx_data, seq_rx_data = '0;
  logic seq_tx_empty, seq_tx_pop = 1'b0, seq_rx_push = 1'b0, seq_rx_full;
  logic ev_done = 1'b0, ev_addr_nak = 1'b0, ev_data_nak = 1'b0, irq;

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  logic [7:0] model [16];
  int mcount;
  logic [31:0] rd;

  always #2 clk = ~clk;

  i2ch_front u_i2ch_front (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .seq_start(seq_start), .seq_accept(seq_accept), .seq_busy(seq_busy),
    .seq_master_en(seq_master_en), .seq_ten_bit(seq_ten_bit),
    .seq_read(seq_read), .seq_combined(seq_combined),
    .seq_dev_addr(seq_dev_addr), .seq_rx_count(seq_rx_count),
    .seq_div_fast(seq_div_fast), .seq_div_hs(seq_div_hs),
    .seq_tx_data(seq_tx_data), .seq_tx_empty(seq_tx_empty),
    .seq_tx_pop(seq_tx_pop), .seq_rx_data(seq_rx_data),
    .seq_rx_push(seq_rx_push), .seq_rx_full(seq_rx_full),
    .ev_done(ev_done), .ev_addr_nak(ev_addr_nak), .ev_data_nak(ev_data_nak),
    .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rx_feed(input logic [7:0] b);
    @(negedge clk);
    seq_rx_data = b; seq_rx_push = 1'b1;
    @(negedge clk);
    seq_rx_push = 1'b0;
  endtask

  function automatic logic [31:0] stat_exp(input logic d, input logic an, input logic dn);
    return {29'd0, dn, an, d};
  endfunction

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // reset state
    bus_read(6'h04, rd); check("R1 reset cmd", rd, 0);
    bus_read(6'h28, rd); check("R1 reset status", rd, 0);
    check("R11 reset irq", {31'd0, irq}, 0);
    check("R5 reset tx empty", {31'd0, seq_tx_empty}, 1);

    // R1 register map
    bus_write(6'h14, 32'h1234_5678);
    bus_write(6'h18, 32'h0000_ABCD);
    bus_read(6'h14, rd); check("R1 fast div readback", rd, 32'h1234_5678);
    check("R1 fast div port", seq_div_fast, 32'h1234_5678);
    check("R1 hs div port", seq_div_hs, 32'h0000_ABCD);
    bus_write(6'h10, 32'hFFFF_FFD5);
    bus_write(6'h0C, 32'h0000_00FD);
    bus_read(6'h10, rd); check("R1 addr low", rd, 32'h55);
    bus_read(6'h0C, rd); check("R1 addr high", rd, 32'h5);
    check("R1 dev addr", {22'd0, seq_dev_addr}, 32'h2D5);
    bus_read(6'h2C, rd); check("R1 unmapped", rd, 0);

    // R2 command bits
    bus_write(6'h04, 32'h0000_003F);
    bus_read(6'h04, rd); check("R2 cmd readback", rd, 32'h3B);
    check("R2 seq flags", {28'd0, seq_master_en, seq_ten_bit, seq_read, seq_combined}, 32'hF);
    check("R2 no start", {31'd0, seq_start}, 0);

    // R3 start handshake
    bus_write(6'h04, 32'h0000_007B);
    check("R3 start raised", {31'd0, seq_start}, 1);
    bus_read(6'h04, rd); check("R3 start readback", rd, 32'h7B);
    @(negedge clk); seq_accept = 1'b1;
    @(negedge clk); seq_accept = 1'b0;
    check("R3 start released", {31'd0, seq_start}, 0);

    // R4 start while busy
    seq_busy = 1'b1;
    bus_write(6'h04, 32'h0000_007B);
    check("R4 start while busy", {31'd0, seq_start}, 0);
    seq_busy = 1'b0;

    // R5 / R6 / R8 transmit rounds
    for (int round = 0; round < 5; round++) begin
      int n;
      int got;
      n = (round == 0) ? 17 : $urandom_range(1, 20);
      bus_write(6'h1C, 32'h8F);
      check("R8 tx flush empty", {31'd0, seq_tx_empty}, 1);
      mcount = 0;
      for (int i = 0; i < n; i++) begin
        logic [7:0] b;
        b = 8'($urandom);
        bus_write(6'h24, {24'd0, b});
        if (mcount < 16) begin model[mcount] = b; mcount++; end
      end
      got = 0;
      while (!seq_tx_empty && got < 20) begin
        check("R5 tx order", {24'd0, seq_tx_data}, {24'd0, model[got]});
        @(negedge clk); seq_tx_pop = 1'b1;
        @(negedge clk); seq_tx_pop = 1'b0;
        got++;
      end
      check("R6 tx count after drain", got, mcount);
    end
    bus_read(6'h1C, rd); check("R8 tx cfg readback", rd, 32'hF);

    // R7 receive: directed full case then random rounds
    for (int i = 0; i < 16; i++) begin model[i] = 8'(8'hA0 + i); rx_feed(model[i]); end
    check("R7 rx full", {31'd0, seq_rx_full}, 1);
    rx_feed(8'hEE);
    for (int i = 0; i < 16; i++) begin
      bus_read(6'h24, rd); check("R7 rx order full", rd, {24'd0, model[i]});
    end
    bus_read(6'h24, rd); check("R7 rx empty read", rd, 0);
    for (int round = 0; round < 3; round++) begin
      int n;
      n = $urandom_range(1, 16);
      for (int i = 0; i < n; i++) begin model[i] = 8'($urandom); rx_feed(model[i]); end
      for (int i = 0; i < n; i++) begin
        bus_read(6'h24, rd); check("R7 rx order", rd, {24'd0, model[i]});
      end
      bus_read(6'h24, rd); check("R7 rx drained", rd, 0);
    end

    // R8 receive flush
    rx_feed(8'h11); rx_feed(8'h22); rx_feed(8'h33);
    bus_write(6'h20, 32'h85);
    bus_read(6'h24, rd); check("R8 rx flushed", rd, 0);
    bus_read(6'h20, rd); check("R8 rx cfg readback", rd, 32'h5);
    check("R8 rx count port", {28'd0, seq_rx_count}, 32'h5);

    // R9 status latch (interrupt enabled from last command write)
    @(negedge clk); ev_addr_nak = 1'b1;
    @(negedge clk); ev_addr_nak = 1'b0;
    check("R11 irq on event", {31'd0, irq}, 1);
    bus_read(6'h28, rd); check("R9 addr nak", rd, stat_exp(0, 1, 0));
    @(negedge clk); ev_done = 1'b1;
    @(negedge clk); ev_done = 1'b0;
    bus_read(6'h28, rd); check("R9 done sticky", rd, stat_exp(1, 1, 0));

    // R10 acknowledge
    bus_write(6'h28, 32'h7F);
    bus_read(6'h28, rd); check("R10 no ack bit", rd, stat_exp(1, 1, 0));
    bus_write(6'h28, 32'h80);
    bus_read(6'h28, rd); check("R10 cleared", rd, 0);
    check("R11 irq after clear", {31'd0, irq}, 0);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 6'h28; bus_wdata = 32'h80; ev_data_nak = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; ev_data_nak = 1'b0;
    bus_read(6'h28, rd); check("R10 event beats clear", rd, stat_exp(0, 0, 1));

    // R11 enable gating
    bus_write(6'h04, 32'h01);
    check("R11 irq masked", {31'd0, irq}, 0);
    bus_write(6'h04, 32'h09);
    check("R11 irq unmasked", {31'd0, irq}, 1);
    bus_write(6'h28, 32'h80);
    check("R11 irq cleared", {31'd0, irq}, 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule